// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs machine cycles on a bus that has a 16-bit address. The upper address byte has its own output lines. The lower address byte and the data byte share a single 8-bit group of lines. A requesting core gives a cycle kind, an address and, for writes, a data byte. The sequencer then steps through a fixed series of T-states. It pulses an address strobe during the first T-state, and it drives a memory/IO select and active-low read and write strobes. After the last T-state it returns a one-clock completion pulse.

There are five cycle kinds. An opcode fetch lasts four T-states. A memory read, memory write, I/O read and I/O write each last three. The shared lines carry the low address in T1. After T1 they carry write data, or they are released so that the selected device can return read data. Read data is sampled on the clock edge that ends T3. An internal capture stage holds the low address while the strobe is high and keeps it after the strobe falls, so attached memory sees a full address for the whole cycle.

Top module: `mux_bus_sequencer`

## Requirements
- R1: After reset, read_n and write_n are 1, addr_strobe, mux_oe, busy and done are 0, and rdata is 0.
- R2: Cycle kind codes are: 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write. An accepted fetch keeps busy high for exactly 4 clocks and every other kind for exactly 3. done is high for exactly the one clock after the last T-state.
- R3: addr_upper equals bits 15:8 of the request address in every T-state of the cycle.
- R4: addr_strobe is high in T1 only. In T1, mux_oe is 1 and mux_out equals bits 7:0 of the request address.
- R5: addr_lo_latched equals bits 7:0 of the request address from T1 onward, and it keeps that value after the cycle ends.
- R6: io_sel is 0 during fetch and memory cycles and 1 during I/O cycles.
- R7: In read kinds (0, 1, 3), read_n is low in T2 and T3 only, and mux_oe is 0 from T2 onward. rdata takes the value on mux_in at the edge that ends T3 and is valid while done is high.
- R8: In write kinds (2, 4), write_n is low in T2 and T3 only, mux_oe is 1 and mux_out equals the request write data in T2 and T3, and read_n stays high.
- R9: read_n and write_n are never low in the same clock.
- R10: A request is taken only when the sequencer is idle (neither busy nor done). Requests during a cycle, and requests with kind codes 5 to 7, start no cycle.
- R11: In T4 of an opcode fetch, read_n is high and mux_oe is 0, while addr_upper still holds the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Cycle request |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Data for write kinds |
| busy | output | 1 | High during T-states |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Data captured by the last read |
| addr_upper | output | 8 | Upper address byte |
| mux_out | output | 8 | Shared lines, driven value |
| mux_in | input | 8 | Shared lines, received value |
| mux_oe | output | 1 | Drive enable for shared lines |
| addr_strobe | output | 1 | Low-address strobe, T1 |
| read_n | output | 1 | Active-low read strobe |
| write_n | output | 1 | Active-low write strobe |
| io_sel | output | 1 | 0 memory, 1 I/O |
| addr_lo_latched | output | 8 | Demultiplexed low address |

## Verification
The bench sweeps all five kinds over addresses at both ends of the range and mixed bit patterns. At every T-state it compares every strobe and data line with values it works out from the kind and the T index.

mux_in holds the complement of the read byte until T3 and returns to the complement right after the edge that ends T3. A sequencer that samples one clock early or late therefore returns the wrong byte, which would also happen if the fourth fetch state were treated as a data state.

A second request with a different address arrives in the middle of each cycle. A design that accepts requests while busy, or that reloads its address register from the request, would change addr_upper or stretch the cycle. Unused kind codes are also sent, and a sequencer that does not filter them would start a cycle.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

  typedef enum logic [2:0] {
    KIND_FETCH = 3'd0,
    KIND_MRD   = 3'd1,
    KIND_MWR   = 3'd2,
    KIND_IORD  = 3'd3,
    KIND_IOWR  = 3'd4
  } cyc_kind_e;

  localparam int TSTATE_MAX = 4;

  function automatic logic kind_ok(input logic [2:0] k);
    return k <= 3'd4;
  endfunction

  function automatic logic [2:0] tstate_count(input logic [2:0] k);
    return (k == 3'd0) ? 3'd4 : 3'd3;
  endfunction

  function automatic logic kind_is_io(input logic [2:0] k);
    return (k == 3'd3) || (k == 3'd4);
  endfunction

  function automatic logic kind_is_write(input logic [2:0] k);
    return (k == 3'd2) || (k == 3'd4);
  endfunction

endpackage

// File: rtl/busseq_tstate_ctrl.sv
module busseq_tstate_ctrl
  import busseq_pkg::*;
#(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  output logic          accept,
  output logic          busy,
  output logic          done,
  output logic [2:0]    kind,
  output logic [TW-1:0] tidx,
  output logic          t_first,
  output logic          t_last
);

  logic          busy_q, done_q;
  logic [2:0]    kind_q;
  logic [TW-1:0] tidx_q;

  assign accept  = req_valid && !busy_q && !done_q && kind_ok(req_kind);
  assign t_first = busy_q && (tidx_q == '0);
  assign t_last  = busy_q && (tidx_q == TW'(tstate_count(kind_q) - 3'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      kind_q <= 3'd0;
      tidx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        kind_q <= req_kind;
        tidx_q <= '0;
      end else if (t_last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else if (busy_q) begin
        tidx_q <= tidx_q + 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign kind = kind_q;
  assign tidx = tidx_q;

  AST_TIDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ({1'b0, tidx_q} < (TW+1)'(tstate_count(kind_q)))); // R2
  AST_KEEP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !t_last) |=> busy_q); // R10

endmodule

// File: rtl/busseq_addr_latch.sv
module busseq_addr_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= '0;
    else if (strobe) held_q <= d;
  end

  // transparent while the strobe is high, holding afterwards
  assign q = strobe ? d : held_q;

endmodule

// File: rtl/mux_bus_sequencer.sv
module mux_bus_sequencer
  import busseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [2:0]      req_kind,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   rdata,
  output logic [AW-DW-1:0] addr_upper,
  output logic [DW-1:0]   mux_out,
  input  logic [DW-1:0]   mux_in,
  output logic            mux_oe,
  output logic            addr_strobe,
  output logic            read_n,
  output logic            write_n,
  output logic            io_sel,
  output logic [DW-1:0]   addr_lo_latched
);

  localparam int TW = $clog2(TSTATE_MAX) + 1;
  localparam int HW = AW - DW;

  logic          accept, t_first, t_last;
  logic [2:0]    kind;
  logic [TW-1:0] tidx;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  busseq_tstate_ctrl #(.TW(TW)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .accept(accept), .busy(busy), .done(done), .kind(kind), .tidx(tidx),
    .t_first(t_first), .t_last(t_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // named T-state events
  logic in_data, is_wr, is_rd, sample_now;
  assign in_data    = busy && ((tidx == TW'(1)) || (tidx == TW'(2)));
  assign is_wr      = kind_is_write(kind);
  assign is_rd      = !is_wr;
  assign sample_now = busy && is_rd && (tidx == TW'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata_q <= '0;
    else if (sample_now) rdata_q <= mux_in;
  end

  assign rdata       = rdata_q;
  assign addr_strobe = t_first;
  assign read_n      = !(in_data && is_rd);
  assign write_n     = !(in_data && is_wr);
  assign mux_oe      = t_first || (in_data && is_wr);
  assign mux_out     = t_first ? addr_q[DW-1:0] : wdata_q;
  assign addr_upper  = addr_q[AW-1 -: HW];
  assign io_sel      = busy && kind_is_io(kind);

  busseq_addr_latch #(.W(DW)) i_lat (
    .clk(clk), .rst_n(rst_n), .strobe(addr_strobe), .d(mux_out),
    .q(addr_lo_latched)
  );

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!read_n && !write_n)); // R9
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |=> !addr_strobe); // R4
  AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !t_first) |-> $stable(addr_upper)); // R3
  AST_IOSEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !t_first) |-> $stable(io_sel)); // R6
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    t_last |=> (done && !busy)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !read_n |-> !mux_oe); // R7
  AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !write_n |-> mux_oe); // R8
  AST_LAT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr_strobe) |-> (addr_lo_latched == $past(mux_out))); // R5

endmodule

// File: tb/test_mux_bus_sequencer.sv
module test_mux_bus_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_kind = 3'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0] req_wdata = 8'h0;
  logic [7:0] mux_in = 8'h0;
  logic       busy, done, mux_oe, addr_strobe, read_n, write_n, io_sel;
  logic [7:0] rdata, addr_upper, mux_out, addr_lo_latched;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  logic [7:0] last_rd = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mux_bus_sequencer i_mux_bus_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .addr_upper(addr_upper), .mux_out(mux_out), .mux_in(mux_in),
    .mux_oe(mux_oe), .addr_strobe(addr_strobe), .read_n(read_n),
    .write_n(write_n), .io_sel(io_sel), .addr_lo_latched(addr_lo_latched)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic run_cycle(input logic [2:0] k, input logic [15:0] a,
                           input logic [7:0] wd, input logic [7:0] rv);
    int  n;
    logic isw, isio;
    n    = (k == 3'd0) ? 4 : 3;
    isw  = (k == 3'd2) || (k == 3'd4);
    isio = (k == 3'd3) || (k == 3'd4);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd; mux_in = ~rv;
    for (int t = 1; t <= n; t++) begin
      logic e_rd, e_wr, e_oe;
      @(negedge clk);
      e_rd = !isw && (t == 2 || t == 3);
      e_wr = isw && (t == 2 || t == 3);
      e_oe = (t == 1) || e_wr;
      chk(busy == 1'b1 && done == 1'b0, "R2 busy in T-state", {busy, done}, 2);
      chk(addr_strobe == (t == 1), "R4 strobe", addr_strobe, (t == 1));
      chk(addr_upper == a[15:8], "R3 upper addr", addr_upper, a[15:8]);
      chk(io_sel == isio, "R6 io select", io_sel, isio);
      chk(read_n == !e_rd, (t == 4) ? "R11 read strobe T4" : "R7 read strobe", read_n, !e_rd);
      chk(write_n == !e_wr, "R8 write strobe", write_n, !e_wr);
      chk(!(read_n == 1'b0 && write_n == 1'b0), "R9 exclusive strobes", {read_n, write_n}, 3);
      chk(mux_oe == e_oe, (t == 4) ? "R11 release T4" : "R7 drive enable", mux_oe, e_oe);
      if (t == 1) chk(mux_out == a[7:0], "R4 low addr on lines", mux_out, a[7:0]);
      if (e_wr)   chk(mux_out == wd, "R8 write data", mux_out, wd);
      chk(addr_lo_latched == a[7:0], "R5 latched low", addr_lo_latched, a[7:0]);
      if (t == 1) req_valid = 1'b0;
      if (t == 2) begin req_valid = 1'b1; req_kind = 3'd1; req_addr = ~a; end // R10 intrusion
      if (t == 3) begin req_valid = 1'b0; mux_in = rv; end
      if (t == 4) mux_in = ~rv;
    end
    @(negedge clk);
    mux_in = ~rv;
    if (!isw) last_rd = rv;
    chk(done == 1'b1 && busy == 1'b0, "R2 done after last T", {busy, done}, 1);
    chk(rdata == last_rd, "R7 read data sample", rdata, last_rd);
    chk(read_n && write_n && !addr_strobe, "R2 bus quiet at done", {read_n, write_n, addr_strobe}, 6);
    chk(addr_lo_latched == a[7:0], "R5 latched hold", addr_lo_latched, a[7:0]);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10 no cycle from intrusion", {busy, done}, 0);
    chk(addr_upper == a[15:8], "R10 address kept", addr_upper, a[15:8]);
  endtask

  task automatic bad_kind(input logic [2:0] k);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = 16'hBEEF;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b0 && addr_strobe == 1'b0, "R10 unused kind ignored", {busy, addr_strobe}, 0);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R10 unused kind no done", {busy, done}, 0);
  endtask

  initial begin
    logic [15:0] addrs [6];
    addrs[0] = 16'h0000; addrs[1] = 16'hFFFF; addrs[2] = 16'hA55A;
    addrs[3] = 16'h1234; addrs[4] = 16'h00FF; addrs[5] = 16'hFF00;
    repeat (3) @(negedge clk);
    chk(read_n && write_n, "R1 reset strobes", {read_n, write_n}, 3);
    chk(!addr_strobe && !mux_oe && !busy && !done, "R1 reset idle",
        {addr_strobe, mux_oe, busy, done}, 0);
    chk(rdata == 8'h00, "R1 reset rdata", rdata, 0);
    rst_n = 1'b1;
    for (int ai = 0; ai < 6; ai++) begin
      for (int k = 0; k < 5; k++) begin
        logic [7:0] wd, rv;
        wd = addrs[ai][7:0] ^ 8'(k * 37 + 11);
        rv = addrs[ai][15:8] + 8'(k * 53 + 7);
        run_cycle(3'(k), addrs[ai], wd, rv);
      end
    end
    bad_kind(3'd5); bad_kind(3'd6); bad_kind(3'd7);
    run_cycle(3'd0, 16'h7E81, 8'h00, 8'hC3);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cyc >= WATCHDOG);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule